// File: doc/BRIEF.md
# SDRAM Mode-Driven Command Sequencer

This block sits between a simple host access port and the command pins of an SDRAM. It has no built-in initialization engine. Software writes a three-bit mode register. While that register holds a special mode, every host write access becomes exactly one SDRAM command of the selected kind: a NOP, a precharge of all banks, an auto-refresh or a load of the device mode register. No data is written in that case. Software therefore runs the power-on sequence itself: NOP, precharge, eight refreshes and a mode load, then a return to normal mode followed by one further write access.

After reset the block holds every command pin high for a programmable power-up wait and stalls the host during that time. In normal mode a refresh timer raises an auto-refresh request every N clocks, where N is written by software. Such a request is served ahead of any waiting host access. A timer value of zero turns automatic refresh off.

The controller has four states. `ST_PWRUP` is the power-up hold. `ST_IDLE` drives NOP. `ST_REF` issues an automatic refresh for one clock. `ST_HOST` serves a host access for one clock. Its transitions are:
- PWRUP→IDLE when the wait has elapsed.
- IDLE→REF when a refresh is pending.
- IDLE→HOST when a host request is present and no refresh is pending.
- REF→IDLE and HOST→IDLE unconditionally.

Top module: `sdram_cmd_seq`

## Requirements
- R1: From reset release, for exactly PWRUP_CYC clocks, sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n are all high and acc_ready stays low.
- R2: After the power-up wait, every clock that carries no command drives NOP: {cs_n,ras_n,cas_n,we_n} = 0111.
- R3: In mode 1, 2, 3 or 4, a host write access issues one command with {cs_n,ras_n,cas_n,we_n} encoded as follows. Mode 1 gives NOP (0111). Mode 2 gives all-bank precharge (0010). Mode 3 gives mode-register load (0000). Mode 4 gives auto-refresh (0001). The command lasts one clock, acc_ready is high in that same clock, and with no refresh pending it comes in the second clock after acc_req is first sampled.
- R4: A precharge drives sd_addr bit 10 high and all other address bits low. NOP and auto-refresh drive sd_addr to zero.
- R5: A mode-register load drives burst length on sd_addr[2:0], a zero on sd_addr[3] and CAS latency on sd_addr[6:4], with all higher bits zero.
- R6: A write access in mode 0, a write in modes 5 to 7, and any read access (acc_we low) are each acknowledged with NOP on the pins and a zero address.
- R7: In mode 0, with a nonzero refresh count N written, an auto-refresh (0001) appears on the pins every N clocks.
- R8: No automatic refresh appears while the mode is nonzero or while the refresh count is zero.
- R9: A pending refresh is issued before a waiting host access. acc_ready stays low while refreshes keep winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | New mode value |
| rtmr_we | input | 1 | Write strobe for the refresh count |
| rtmr_wdata | input | TIMER_W | Refresh interval in clocks, 0 disables |
| cas_lat | input | 3 | CAS latency placed on the address by a mode load |
| burst_len | input | 3 | Burst length code placed on the address by a mode load |
| acc_req | input | 1 | Host access request, held until acc_ready |
| acc_we | input | 1 | Host access is a write |
| acc_ready | output | 1 | One-clock acknowledge of the host access |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address lines |

## Verification
The bench drives the full software initialization order with each mode in turn. This separates the four command encodings and shows that each access yields exactly one command. Two different CAS latency and burst length pairs tell a correct mode-load field placement apart from a swapped or shifted one. Writes in mode 0, writes in an unused mode and a read in a special mode must all produce a bare NOP acknowledge. The refresh timer is exercised in four settings: a running interval, a nonzero mode, a zero count, and a count of 2 that starves a waiting host until the count is cleared. Together these show the interval length, the mode gating and the priority of refresh over the host.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_NOP     = 3'd1,
        MODE_PRECHG  = 3'd2,
        MODE_LOADMR  = 3'd3,
        MODE_AUTOREF = 3'd4
    } seq_mode_e;

    // Pin order {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PINS_DESEL = 4'b1111;
    localparam logic [3:0] PINS_NOP   = 4'b0111;
    localparam logic [3:0] PINS_PRE   = 4'b0010;
    localparam logic [3:0] PINS_REF   = 4'b0001;
    localparam logic [3:0] PINS_MRS   = 4'b0000;

    function automatic logic [3:0] mode_to_pins(input logic [2:0] mode, input logic is_write);
        logic [3:0] p;
        p = PINS_NOP;
        if (is_write) begin
            unique case (mode)
                MODE_PRECHG:  p = PINS_PRE;
                MODE_LOADMR:  p = PINS_MRS;
                MODE_AUTOREF: p = PINS_REF;
                default:      p = PINS_NOP;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/sdram_pwrup_wait.sv
module sdram_pwrup_wait #(
    parameter int PWRUP_CYC = 40000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwrup_done
);
    localparam int CW = (PWRUP_CYC > 2) ? $clog2(PWRUP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PWRUP_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign pwrup_done = (cnt_q == LAST);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int TIMER_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               rtmr_we,
    input  logic [TIMER_W-1:0] rtmr_wdata,
    input  logic               ref_ack,
    output logic               ref_pend
);
    logic [TIMER_W-1:0] rtmr_q;
    logic [TIMER_W-1:0] cnt_q;
    logic               active;
    logic               tick;

    assign active = run && (rtmr_q != '0);
    assign tick   = active && !rtmr_we && (cnt_q == rtmr_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtmr_q <= '0;
            cnt_q  <= '0;
        end else if (rtmr_we) begin
            rtmr_q <= rtmr_wdata;
            cnt_q  <= '0;
        end else if (active) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ref_pend <= 1'b0;
        else if (active) ref_pend <= (ref_pend && !ref_ack) || tick;
        else             ref_pend <= 1'b0;
    end
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrup_done,
    input  logic              ref_pend,
    input  logic [2:0]        mode,
    input  logic [2:0]        cas_lat,
    input  logic [2:0]        burst_len,
    input  logic              acc_req,
    input  logic              acc_we,
    output logic              acc_ready,
    output logic              ref_ack,
    output logic [3:0]        pins,
    output logic [ADDR_W-1:0] addr
);
    typedef enum logic [1:0] {ST_PWRUP, ST_IDLE, ST_REF, ST_HOST} st_e;

    st_e        state_q, state_d;
    logic [3:0] cmd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: if (pwrup_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (ref_pend)     state_d = ST_REF;
                else if (acc_req) state_d = ST_HOST;
            end
            ST_REF:  state_d = ST_IDLE;
            ST_HOST: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
            cmd_q   <= PINS_NOP;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && !ref_pend && acc_req)
                cmd_q <= mode_to_pins(mode, acc_we);
        end
    end

    always_comb begin
        pins      = PINS_NOP;
        acc_ready = 1'b0;
        ref_ack   = 1'b0;
        unique case (state_q)
            ST_PWRUP: pins = PINS_DESEL;
            ST_IDLE:  pins = PINS_NOP;
            ST_REF: begin
                pins    = PINS_REF;
                ref_ack = 1'b1;
            end
            ST_HOST: begin
                pins      = cmd_q;
                acc_ready = 1'b1;
            end
        endcase
        addr = '0;
        if (pins == PINS_PRE)      addr[10]  = 1'b1;
        else if (pins == PINS_MRS) addr[6:0] = {cas_lat, 1'b0, burst_len};
    end

    assert_ready_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |=> !acc_ready);

    assert_ref_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ref_pend && acc_req) |=> !acc_ready);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int TIMER_W   = 12,
    parameter int PWRUP_CYC = 40000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_we,
    input  logic [2:0]         mode_wdata,
    input  logic               rtmr_we,
    input  logic [TIMER_W-1:0] rtmr_wdata,
    input  logic [2:0]         cas_lat,
    input  logic [2:0]         burst_len,
    input  logic               acc_req,
    input  logic               acc_we,
    output logic               acc_ready,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [ADDR_W-1:0]  sd_addr
);
    logic [2:0] mode_q;
    logic       pwrup_done;
    logic       ref_pend;
    logic       ref_ack;
    logic [3:0] pins;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= MODE_NORMAL;
        else if (mode_we) mode_q <= mode_wdata;
    end

    sdram_pwrup_wait #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
        .clk(clk), .rst_n(rst_n), .pwrup_done(pwrup_done)
    );

    sdram_refresh_timer #(.TIMER_W(TIMER_W)) u_rtmr (
        .clk(clk), .rst_n(rst_n),
        .run(pwrup_done && (mode_q == MODE_NORMAL)),
        .rtmr_we(rtmr_we), .rtmr_wdata(rtmr_wdata),
        .ref_ack(ref_ack), .ref_pend(ref_pend)
    );

    sdram_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwrup_done(pwrup_done), .ref_pend(ref_pend),
        .mode(mode_q), .cas_lat(cas_lat), .burst_len(burst_len),
        .acc_req(acc_req), .acc_we(acc_we), .acc_ready(acc_ready),
        .ref_ack(ref_ack), .pins(pins), .addr(sd_addr)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;

    assert_quiet_pwrup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrup_done |-> (sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !acc_ready));

    assert_cmd_one_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !(sd_ras_n && sd_cas_n && sd_we_n)) |=>
        (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

    assert_pre_a10_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

    assert_ref_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n && !acc_ready) |-> $past(ref_pend));
endmodule

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;
    localparam int AW = 13;
    localparam int TW = 12;
    localparam int PW = 40000;

    typedef struct packed {
        logic [3:0]    pins;
        logic [AW-1:0] addr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0;
    logic [2:0]    mode_wdata = '0;
    logic          rtmr_we = 1'b0;
    logic [TW-1:0] rtmr_wdata = '0;
    logic [2:0]    cas_lat = 3'd3;
    logic [2:0]    burst_len = 3'd2;
    logic          acc_req = 1'b0;
    logic          acc_we = 1'b0;
    logic          acc_ready;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;

    int   errors = 0;
    int   checks = 0;
    int   ref_cnt = 0;
    int   prev_ref = 0;
    int   last_ref = 0;
    int   cyc = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_seq #(.ADDR_W(AW), .TIMER_W(TW), .PWRUP_CYC(PW)) i_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .rtmr_we(rtmr_we), .rtmr_wdata(rtmr_wdata), .cas_lat(cas_lat),
        .burst_len(burst_len), .acc_req(acc_req), .acc_we(acc_we),
        .acc_ready(acc_ready), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per acknowledged access, logs refreshes
    always @(negedge clk) begin
        if (rst_n && !acc_ready && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) begin
            ref_cnt  <= ref_cnt + 1;
            prev_ref <= last_ref;
            last_ref <= cyc;
        end else if (rst_n && acc_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 unexpected ack", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e.pins, "R3/R6 pins",
                      int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(e.pins));
                check(sd_addr == e.addr, "R4/R5 addr", int'(sd_addr), int'(e.addr));
            end
        end else if (rst_n && sd_cs_n == 1'b0 &&
                     {sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) begin
            check(1'b0, "R2 stray command", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        end
    end

    task automatic set_mode(input logic [2:0] m);
        @(posedge clk); #1 mode_we = 1'b1; mode_wdata = m;
        @(posedge clk); #1 mode_we = 1'b0;
    endtask

    task automatic set_rtmr(input int v);
        @(posedge clk); #1 rtmr_we = 1'b1; rtmr_wdata = TW'(v);
        @(posedge clk); #1 rtmr_we = 1'b0;
    endtask

    // Driver: pushes the expectation, then runs the access
    task automatic access(input logic we, input logic [3:0] ep, input logic [AW-1:0] ea,
                          input bit chk_lat, input string req);
        int n;
        exp_t e;
        e.pins = ep; e.addr = ea;
        sb_q.push_back(e);
        @(posedge clk); #1 acc_req = 1'b1; acc_we = we;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!acc_ready && n < 200);
        if (chk_lat) check(n == 2, req, n, 2);
        @(posedge clk); #1 acc_req = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, acc_ready} == 5'b11110, "R1 reset state",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, acc_ready}), 5'b11110);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: count held-high clocks
        n = 0;
        begin
            bit bad = 0;
            forever begin
                @(negedge clk);
                if (!sd_cs_n) break;
                n++;
                if (!(sd_ras_n && sd_cas_n && sd_we_n && !acc_ready)) bad = 1;
            end
            check(!bad, "R1 pins quiet during wait", bad, 0);
        end
        check(n == PW, "R1 power-up length", n, PW);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R2 NOP after wait",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);

        // Initialization order
        set_mode(3'd1); access(1'b1, 4'b0111, '0, 1, "R3 NOP latency");
        set_mode(3'd2); access(1'b1, 4'b0010, AW'(1) << 10, 1, "R3 precharge latency");
        set_mode(3'd4);
        for (int i = 0; i < 8; i++) access(1'b1, 4'b0001, '0, 1, "R3 refresh latency");
        cas_lat = 3'd3; burst_len = 3'd2;
        set_mode(3'd3); access(1'b1, 4'b0000, AW'(7'b0110010), 1, "R5 mode load");
        set_mode(3'd0); access(1'b1, 4'b0111, '0, 1, "R6 normal write");
        check(ref_cnt == 0, "R8 no auto refresh with zero count", ref_cnt, 0);

        // R5 second field pair
        cas_lat = 3'd2; burst_len = 3'd3;
        set_mode(3'd3); access(1'b1, 4'b0000, AW'(7'b0100011), 1, "R5 mode load 2");
        // R6 read in special mode, unused mode
        set_mode(3'd2); access(1'b0, 4'b0111, '0, 1, "R6 read in precharge mode");
        set_mode(3'd5); access(1'b1, 4'b0111, '0, 1, "R6 unused mode");
        set_mode(3'd0);

        // R7 interval
        set_rtmr(20);
        base = ref_cnt;
        wait_cyc(100);
        @(negedge clk);
        check(ref_cnt - base >= 4, "R7 refreshes seen", ref_cnt - base, 4);
        check(last_ref - prev_ref == 20, "R7 interval 20", last_ref - prev_ref, 20);

        // R8 nonzero mode stops refresh
        set_mode(3'd1);
        set_rtmr(10);
        wait_cyc(3);
        base = ref_cnt;
        wait_cyc(50);
        check(ref_cnt == base, "R8 no refresh in mode 1", ref_cnt - base, 0);
        set_mode(3'd0);
        wait_cyc(50);
        @(negedge clk);
        check(ref_cnt - base >= 4, "R7 refresh resumes", ref_cnt - base, 4);
        check(last_ref - prev_ref == 10, "R7 interval 10", last_ref - prev_ref, 10);

        // R8 zero count
        set_rtmr(0);
        wait_cyc(3);
        base = ref_cnt;
        wait_cyc(50);
        check(ref_cnt == base, "R8 zero count disables", ref_cnt - base, 0);

        // R9 refresh beats host
        set_rtmr(2);
        wait_cyc(6);
        base = ref_cnt;
        begin
            exp_t e;
            bit seen;
            e.pins = 4'b0111; e.addr = '0;
            sb_q.push_back(e);
            @(posedge clk); #1 acc_req = 1'b1; acc_we = 1'b1;
            seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (acc_ready) seen = 1;
            end
            check(!seen, "R9 host held while refresh pending", seen, 0);
            check(ref_cnt - base >= 8, "R9 refreshes served first", ref_cnt - base, 8);
            @(posedge clk); #1 rtmr_we = 1'b1; rtmr_wdata = '0;
            @(posedge clk); #1 rtmr_we = 1'b0;
            repeat (10) begin
                @(negedge clk);
                if (acc_ready) seen = 1;
                if (acc_ready) break;
            end
            check(seen, "R9 host served once refresh stops", seen, 1);
            @(posedge clk); #1 acc_req = 1'b0;
        end

        wait_cyc(5);
        check(sb_q.size() == 0, "R3 all accesses acknowledged", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule